// File: doc/BRIEF.md
# Column-Command Data Return Pipeline

This block is the data-bus half of a DRAM channel controller. Each column command that the bank scheduler issues enters a delay line. It waits there for the access latency before its data phase starts. The latency is the CAS latency for reads and the write latency for writes, and it is chosen by the bus direction of the most recently accepted command. Every command that leaves the line moves one burst of data. A per-tag byte accumulator adds that burst to the request's running total. The request is finished once the total covers the size that the command carries, and its tag is then pushed into a return queue. The queue drains through a valid/ready stream.

The bus direction is tracked by a two-state machine. `DIR_READ` is the reset state, and in it the minimum residency is `CAS_LAT`. `DIR_WRITE` uses a minimum residency of `WR_LAT`. The transition *read-to-write* fires when an accepted command has `cmd_write=1` while the machine is in `DIR_READ`. The transition *write-to-read* fires when an accepted command has `cmd_write=0` while the machine is in `DIR_WRITE`. Each state otherwise holds.

The delay line holds at most `CAS_LAT+1` commands and raises `line_full` when it is at capacity. Nothing leaves the line while the return queue is full. A return-queue depth of zero selects a variant with no storage and no backpressure. In that variant each completion pulses `rsp_valid` for one cycle and `rsp_ready` is ignored.

Top module: `burst_return_pipe`

## Requirements
- R1: After reset `rsp_valid` and `line_full` are 0 and the bus direction is read.
- R2: A read command whose byte total is at most one burst (BURST_BYTES = 16 by default, and a total of 0 counts as one burst) is accepted at edge E. It appears on `rsp_valid`/`rsp_tag` after edge E+CAS_LAT.
- R3: An accepted command with `cmd_write=1` moves the direction to write, and an accepted command with `cmd_write=0` moves it to read. A command accepted in write direction reaches the return queue WR_LAT edges after its acceptance edge.
- R4: Each command that leaves the line adds BURST_BYTES to the accumulator of its tag. The tag is returned only by the command that brings the accumulator to at least `cmd_bytes`, and that accumulator then restarts at 0. Earlier commands of the same request produce no response.
- R5: Completions leave in the order their final commands were accepted, one per cycle when `rsp_ready` is 1.
- R6: While the return queue is full, no command leaves the delay line.
- R7: The line holds at most CAS_LAT+1 commands and `line_full` is 1 exactly when it is at capacity. A command presented while `line_full` is 1 is dropped and never produces a response.
- R8: While `rsp_valid` is 1 and `rsp_ready` is 0, `rsp_valid` stays 1 and `rsp_tag` stays stable.
- R9: With RET_DEPTH = 0, each completion pulses `rsp_valid` for one cycle regardless of `rsp_ready`, and the line never stalls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Column command presented |
| cmd_write | input | 1 | 1 = write command, 0 = read command |
| cmd_tag | input | TAG_W | Request tag |
| cmd_bytes | input | BYTES_W | Total byte size of the request |
| line_full | output | 1 | Delay line at capacity; commands are dropped |
| rsp_valid | output | 1 | Completed request available |
| rsp_ready | input | 1 | Consumer takes the completed request |
| rsp_tag | output | TAG_W | Tag of the completed request |

## Verification
A wrong direction state changes the command-to-response distance by CAS_LAT-WR_LAT cycles on the very next command. A wrong residency count shifts that distance even without any direction change. A corrupted byte accumulator shows up when a multi-burst request is finished: the response comes one or more bursts early, or it never comes. Lost stall or capacity tracking shows up within a few cycles of backpressure, as a missing, duplicated or reordered tag, or as `line_full` asserting at the wrong fill level.

// File: rtl/burst_ret_pkg.sv
package burst_ret_pkg;
    typedef enum logic {
        DIR_READ  = 1'b0,
        DIR_WRITE = 1'b1
    } bus_dir_e;

    function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction
endpackage

// File: rtl/cas_delay_line.sv
module cas_delay_line #(
    parameter int unsigned DEPTH   = 5,
    parameter int unsigned DATA_W  = 12,
    parameter int unsigned AGE_MAX = 4
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               push,
    input  logic [DATA_W-1:0]                  push_data,
    input  logic                               drain_ok,
    input  logic [$clog2(AGE_MAX+1)-1:0]       min_age,
    output logic                               full,
    output logic                               pop,
    output logic [DATA_W-1:0]                  head_data,
    output logic [$clog2(DEPTH+1)-1:0]         level
);
    localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int unsigned CNT_W = $clog2(DEPTH+1);
    localparam int unsigned AGE_W = $clog2(AGE_MAX+1);

    logic [DATA_W-1:0] slot_data [DEPTH];
    logic [AGE_W-1:0]  slot_age  [DEPTH];
    logic [PTR_W-1:0]  wr_ptr, rd_ptr;
    logic              do_push;

    assign full      = (level == CNT_W'(DEPTH));
    assign do_push   = push && !full;
    assign pop       = (level != '0) && (slot_age[rd_ptr] >= min_age) && drain_ok;
    assign head_data = slot_data[rd_ptr];

    // per-slot residency counters, saturating at the largest latency
    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                slot_age[g] <= '0;
            end else if (do_push && (wr_ptr == PTR_W'(g))) begin
                slot_age[g] <= AGE_W'(1);
            end else if (slot_age[g] != AGE_W'(AGE_MAX)) begin
                slot_age[g] <= slot_age[g] + AGE_W'(1);
            end
        end

        always_ff @(posedge clk) begin
            if (do_push && (wr_ptr == PTR_W'(g))) begin
                slot_data[g] <= push_data;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            level  <= '0;
        end else begin
            if (do_push) begin
                wr_ptr <= (wr_ptr == PTR_W'(DEPTH-1)) ? '0 : wr_ptr + PTR_W'(1);
            end
            if (pop) begin
                rd_ptr <= (rd_ptr == PTR_W'(DEPTH-1)) ? '0 : rd_ptr + PTR_W'(1);
            end
            unique case ({do_push, pop})
                2'b10:   level <= level + CNT_W'(1);
                2'b01:   level <= level - CNT_W'(1);
                default: level <= level;
            endcase
        end
    end
endmodule

// File: rtl/burst_accum.sv
module burst_accum #(
    parameter int unsigned TAG_W       = 4,
    parameter int unsigned BYTES_W     = 8,
    parameter int unsigned BURST_BYTES = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               beat,
    input  logic [TAG_W-1:0]   beat_tag,
    input  logic [BYTES_W-1:0] beat_total,
    output logic               done,
    output logic [TAG_W-1:0]   done_tag
);
    localparam int unsigned NTAGS = 1 << TAG_W;

    logic [BYTES_W-1:0] moved [NTAGS];
    logic [BYTES_W:0]   sum;

    assign sum      = {1'b0, moved[beat_tag]} + (BYTES_W+1)'(BURST_BYTES);
    assign done     = beat && (sum >= {1'b0, beat_total});
    assign done_tag = beat_tag;

    for (genvar g = 0; g < NTAGS; g++) begin : g_tag
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                moved[g] <= '0;
            end else if (beat && (beat_tag == TAG_W'(g))) begin
                moved[g] <= done ? '0 : sum[BYTES_W-1:0];
            end
        end
    end
endmodule

// File: rtl/return_fifo.sv
module return_fifo #(
    parameter int unsigned DEPTH = 2,
    parameter int unsigned W     = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] push_data,
    output logic         full,
    output logic         out_valid,
    input  logic         out_ready,
    output logic [W-1:0] out_data
);
    if (DEPTH == 0) begin : g_pass
        // no storage: completions stream out and never backpressure
        logic         vld_q;
        logic [W-1:0] dat_q;
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                vld_q <= 1'b0;
                dat_q <= '0;
            end else begin
                vld_q <= push;
                dat_q <= push_data;
            end
        end
        assign full      = 1'b0;
        assign out_valid = vld_q;
        assign out_data  = dat_q;
    end else begin : g_queue
        localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
        localparam int unsigned CNT_W = $clog2(DEPTH+1);
        logic [W-1:0]     mem [DEPTH];
        logic [PTR_W-1:0] wp, rp;
        logic [CNT_W-1:0] cnt;
        logic             take, put;

        assign full      = (cnt == CNT_W'(DEPTH));
        assign out_valid = (cnt != '0);
        assign out_data  = mem[rp];
        assign take      = out_valid && out_ready;
        assign put       = push && !full;

        always_ff @(posedge clk) begin
            if (put) mem[wp] <= push_data;
        end

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                wp  <= '0;
                rp  <= '0;
                cnt <= '0;
            end else begin
                if (put)  wp <= (wp == PTR_W'(DEPTH-1)) ? '0 : wp + PTR_W'(1);
                if (take) rp <= (rp == PTR_W'(DEPTH-1)) ? '0 : rp + PTR_W'(1);
                unique case ({put, take})
                    2'b10:   cnt <= cnt + CNT_W'(1);
                    2'b01:   cnt <= cnt - CNT_W'(1);
                    default: cnt <= cnt;
                endcase
            end
        end
    end
endmodule

// File: rtl/burst_return_pipe.sv
module burst_return_pipe #(
    parameter int unsigned TAG_W      = 4,
    parameter int unsigned BYTES_W    = 8,
    parameter int unsigned CAS_LAT    = 4,
    parameter int unsigned WR_LAT     = 2,
    parameter int unsigned BURST_LEN  = 4,
    parameter int unsigned BUS_BYTES  = 2,
    parameter int unsigned DEVS       = 2,
    parameter int unsigned RET_DEPTH  = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cmd_valid,
    input  logic               cmd_write,
    input  logic [TAG_W-1:0]   cmd_tag,
    input  logic [BYTES_W-1:0] cmd_bytes,
    output logic               line_full,
    output logic               rsp_valid,
    input  logic               rsp_ready,
    output logic [TAG_W-1:0]   rsp_tag
);
    import burst_ret_pkg::*;

    localparam int unsigned LINE_DEPTH  = CAS_LAT + 1;
    localparam int unsigned AGE_MAX     = max_u(CAS_LAT, WR_LAT);
    localparam int unsigned AGE_W       = $clog2(AGE_MAX+1);
    localparam int unsigned LVL_W       = $clog2(LINE_DEPTH+1);
    localparam int unsigned BURST_BYTES = BURST_LEN * BUS_BYTES * DEVS;
    localparam int unsigned ENT_W       = TAG_W + BYTES_W;

    bus_dir_e          dir_q, dir_d;
    logic [AGE_W-1:0]  min_age;
    logic              accept;
    logic              line_pop;
    logic [ENT_W-1:0]  head_data;
    logic [LVL_W-1:0]  line_level;
    logic              rq_full;
    logic              done;
    logic [TAG_W-1:0]  done_tag;

    assign accept = cmd_valid && !line_full;

    // direction state register
    always_ff @(posedge clk) begin
        if (!rst_n) dir_q <= DIR_READ;
        else        dir_q <= dir_d;
    end

    // transitions: read-to-write and write-to-read on accepted commands
    always_comb begin
        dir_d = dir_q;
        unique case (dir_q)
            DIR_READ:  if (accept && cmd_write)  dir_d = DIR_WRITE;
            DIR_WRITE: if (accept && !cmd_write) dir_d = DIR_READ;
            default:   dir_d = DIR_READ;
        endcase
    end

    // state outputs: minimum residency of the delay line
    always_comb begin
        unique case (dir_q)
            DIR_WRITE: min_age = AGE_W'(WR_LAT);
            default:   min_age = AGE_W'(CAS_LAT);
        endcase
    end

    cas_delay_line #(
        .DEPTH   (LINE_DEPTH),
        .DATA_W  (ENT_W),
        .AGE_MAX (AGE_MAX)
    ) line_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (cmd_valid),
        .push_data ({cmd_tag, cmd_bytes}),
        .drain_ok  (!rq_full),
        .min_age   (min_age),
        .full      (line_full),
        .pop       (line_pop),
        .head_data (head_data),
        .level     (line_level)
    );

    burst_accum #(
        .TAG_W       (TAG_W),
        .BYTES_W     (BYTES_W),
        .BURST_BYTES (BURST_BYTES)
    ) accum_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .beat       (line_pop),
        .beat_tag   (head_data[ENT_W-1 -: TAG_W]),
        .beat_total (head_data[BYTES_W-1:0]),
        .done       (done),
        .done_tag   (done_tag)
    );

    return_fifo #(
        .DEPTH (RET_DEPTH),
        .W     (TAG_W)
    ) retq_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (done),
        .push_data (done_tag),
        .full      (rq_full),
        .out_valid (rsp_valid),
        .out_ready (rsp_ready),
        .out_data  (rsp_tag)
    );
endmodule

// File: rtl/burst_return_pipe_chk.sv
module burst_return_pipe_chk #(
    parameter int unsigned TAG_W     = 4,
    parameter int unsigned CAS_LAT   = 4,
    parameter int unsigned WR_LAT    = 2,
    parameter int unsigned RET_DEPTH = 2,
    parameter int unsigned LVL_W     = 3,
    parameter int unsigned AGE_W     = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cmd_valid,
    input logic             cmd_write,
    input logic             line_full,
    input logic             line_pop,
    input logic [LVL_W-1:0] line_level,
    input logic             rq_full,
    input logic [AGE_W-1:0] min_age,
    input logic             rsp_valid,
    input logic             rsp_ready,
    input logic [TAG_W-1:0] rsp_tag
);
    assert_line_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
        line_level <= LVL_W'(CAS_LAT + 1));

    assert_drop_when_full_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (line_full && cmd_valid && !line_pop) |=> (line_level == $past(line_level)));

    assert_stall_on_full_queue_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rq_full |-> !line_pop);

    assert_write_latency_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !line_full && cmd_write) |=> (min_age == AGE_W'(WR_LAT)));

    assert_read_latency_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !line_full && !cmd_write) |=> (min_age == AGE_W'(CAS_LAT)));

    if (RET_DEPTH != 0) begin : g_hold
        assert_rsp_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_tag)));
    end
endmodule

bind burst_return_pipe burst_return_pipe_chk #(
    .TAG_W     (TAG_W),
    .CAS_LAT   (CAS_LAT),
    .WR_LAT    (WR_LAT),
    .RET_DEPTH (RET_DEPTH),
    .LVL_W     (LVL_W),
    .AGE_W     (AGE_W)
) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_valid  (cmd_valid),
    .cmd_write  (cmd_write),
    .line_full  (line_full),
    .line_pop   (line_pop),
    .line_level (line_level),
    .rq_full    (rq_full),
    .min_age    (min_age),
    .rsp_valid  (rsp_valid),
    .rsp_ready  (rsp_ready),
    .rsp_tag    (rsp_tag)
);

// File: tb/burst_return_pipe_tb_top.sv
module burst_return_pipe_tb_top;
    localparam int CL = 4;
    localparam int WL = 2;
    localparam int QD = 2;
    localparam int BB = 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_valid = 1'b0;
    logic       cmd_write = 1'b0;
    logic [3:0] cmd_tag = '0;
    logic [7:0] cmd_bytes = '0;
    logic       rsp_ready = 1'b1;
    logic       line_full, rsp_valid;
    logic [3:0] rsp_tag;
    logic       z_full, z_valid;
    logic [3:0] z_tag;

    int cyc = 0;
    int n_run = 0;
    int n_fail = 0;
    bit done_flag = 0;

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    burst_return_pipe #(.CAS_LAT(CL), .WR_LAT(WL), .RET_DEPTH(QD)) dut_i (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_write(cmd_write),
        .cmd_tag(cmd_tag), .cmd_bytes(cmd_bytes), .line_full(line_full),
        .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_tag(rsp_tag));

    burst_return_pipe #(.CAS_LAT(CL), .WR_LAT(WL), .RET_DEPTH(0)) dut0_i (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_write(cmd_write),
        .cmd_tag(cmd_tag), .cmd_bytes(cmd_bytes), .line_full(z_full),
        .rsp_valid(z_valid), .rsp_ready(1'b0), .rsp_tag(z_tag));

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // one command, accepted at the next edge; returns cycle stamp after that edge
    task automatic issue(input bit wr, input int tg, input int nb, output int t);
        cmd_valid = 1'b1; cmd_write = wr; cmd_tag = 4'(tg); cmd_bytes = 8'(nb);
        @(negedge clk);
        cmd_valid = 1'b0;
        t = cyc;
    endtask

    task automatic wait_rsp(output int t, output int tg, output bit ok);
        ok = 0; t = 0; tg = -1;
        for (int i = 0; i < 40; i++) begin
            if (rsp_valid) begin
                t = cyc; tg = int'(rsp_tag); ok = 1;
                @(negedge clk);
                return;
            end
            @(negedge clk);
        end
    endtask

    task automatic run_tests();
        int t0, t1, tg;
        bit ok;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        chk(rsp_valid == 1'b0, "R1 rsp_valid after reset", int'(rsp_valid), 0);
        chk(line_full == 1'b0, "R1 line_full after reset", int'(line_full), 0);

        // R2: single-burst reads, totals 0..16, latency CAS_LAT
        for (int b = 0; b <= BB; b++) begin
            issue(1'b0, b % 16, b, t0);
            wait_rsp(t1, tg, ok);
            chk(ok && (t1 - t0) == CL, "R2 read latency", t1 - t0, CL);
            chk(tg == b % 16, "R2 read tag", tg, b % 16);
        end

        // R3: direction flips change the residency
        issue(1'b1, 3, 16, t0);
        wait_rsp(t1, tg, ok);
        chk(ok && (t1 - t0) == WL, "R3 write latency after flip", t1 - t0, WL);
        issue(1'b1, 4, 8, t0);
        wait_rsp(t1, tg, ok);
        chk(ok && (t1 - t0) == WL && tg == 4, "R3 write latency held", t1 - t0, WL);
        issue(1'b0, 5, 16, t0);
        wait_rsp(t1, tg, ok);
        chk(ok && (t1 - t0) == CL && tg == 5, "R3 read latency restored", t1 - t0, CL);

        // R4: multi-burst requests, response only after the covering burst
        for (int total = 17; total <= 96; total += 13) begin
            int n = (total + BB - 1) / BB;
            int early = 0;
            int extra = 0;
            cmd_valid = 1'b1; cmd_write = 1'b0; cmd_tag = 4'(9); cmd_bytes = 8'(total);
            for (int k = 0; k < n; k++) begin
                @(negedge clk);
                if (rsp_valid) early++;
            end
            cmd_valid = 1'b0;
            t0 = cyc;
            chk(early == 0, "R4 no response before last burst", early, 0);
            wait_rsp(t1, tg, ok);
            chk(ok && (t1 - t0) == CL && tg == 9, "R4 completion timing", t1 - t0, CL);
            for (int k = 0; k < 8; k++) begin
                if (rsp_valid) extra++;
                @(negedge clk);
            end
            chk(extra == 0, "R4 single completion per request", extra, 0);
        end

        // R5: in-order back-to-back completions
        cmd_valid = 1'b1; cmd_write = 1'b0; cmd_bytes = 8'(16);
        for (int k = 0; k < 5; k++) begin
            cmd_tag = 4'(k + 10);
            @(negedge clk);
        end
        cmd_valid = 1'b0;
        begin
            int prev_t = -1;
            for (int k = 0; k < 5; k++) begin
                wait_rsp(t1, tg, ok);
                chk(ok && tg == k + 10, "R5 completion order", tg, k + 10);
                if (k > 0) chk(t1 - prev_t == 1, "R5 one per cycle", t1 - prev_t, 1);
                prev_t = t1;
            end
        end

        // R6 R7 R8: backpressure, capacity and dropped commands
        rsp_ready = 1'b0;
        begin
            int acc = 0;
            cmd_valid = 1'b1; cmd_write = 1'b0; cmd_bytes = 8'(16);
            for (int k = 0; k < 10; k++) begin
                cmd_tag = 4'(k);
                if (!line_full) acc++;
                @(negedge clk);
            end
            cmd_valid = 1'b0;
            chk(acc == QD + CL + 1, "R7 accepted before full", acc, QD + CL + 1);
            chk(line_full == 1'b1, "R7 line_full at capacity", int'(line_full), 1);
            repeat (10) @(negedge clk);
            chk(line_full == 1'b1, "R6 line stalls while queue full", int'(line_full), 1);
            chk(rsp_valid && rsp_tag == 4'd0, "R8 held response", int'(rsp_tag), 0);
            rsp_ready = 1'b1;
            for (int k = 0; k < QD + CL + 1; k++) begin
                wait_rsp(t1, tg, ok);
                chk(ok && tg == k, "R6 drained order", tg, k);
            end
            acc = 0;
            for (int k = 0; k < 20; k++) begin
                if (rsp_valid) acc++;
                @(negedge clk);
            end
            chk(acc == 0, "R7 dropped commands never return", acc, 0);
            chk(line_full == 1'b0, "R7 line_full clears", int'(line_full), 0);
        end

        // R9: zero-depth variant ignores rsp_ready and never stalls
        begin
            int got = 0;
            int bad = 0;
            cmd_valid = 1'b1; cmd_write = 1'b0; cmd_bytes = 8'(16);
            for (int k = 0; k < 8; k++) begin
                cmd_tag = 4'(k + 2);
                if (z_full) bad++;
                if (z_valid) begin
                    if (int'(z_tag) != got + 2) bad++;
                    got++;
                end
                @(negedge clk);
            end
            cmd_valid = 1'b0;
            for (int k = 0; k < 15; k++) begin
                if (z_valid) begin
                    if (int'(z_tag) != got + 2) bad++;
                    got++;
                end
                @(negedge clk);
            end
            chk(got == 8, "R9 all completions pulse out", got, 8);
            chk(bad == 0, "R9 order and no stall", bad, 0);
        end
    endtask

    initial begin
        @(negedge clk);
        run_tests();
        if (!done_flag) begin
            done_flag = 1;
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done_flag) begin
            done_flag = 1;
            n_run++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule